// File: doc/BRIEF.md
# Urgency-Ordered Two-Counter Transaction Updater

The block holds two shared 16-bit counters, called X and Y, and four guarded update processes that act on them. Each process has one request bit. A process that is granted in a cycle applies all of its changes to X and Y at the same clock edge, as one indivisible step. A process that cannot take every register it needs applies none of its changes.

In any cycle, each counter accepts a change from at most one process. When several requests arrive together, a fixed urgency ranking decides which process is granted. Process 2 has the highest urgency, then process 3, then process 1, and process 0 has the lowest.

Every process touches X, so at most one process is granted per cycle. The counters wrap modulo 2^16. A registered one-hot flag vector shows which process was applied at the most recent edge.

Top module: `atomic_pair_updater`

## Requirements
- R1: While rst_n is low, x_o, y_o and fired_o are all zero, and this holds even when reset is asserted in the middle of operation.
- R2: When cond_i[2] is high, process 2 is granted whatever the other requests are: X increases by 1 and Y decreases by 1 at that edge.
- R3: When cond_i[3] is high and cond_i[2] is low, process 3 is granted: X increases by 2 and Y decreases by 2.
- R4: When cond_i[1] is high and neither cond_i[2] nor cond_i[3] is high, process 1 is granted: X decreases by 1 and Y increases by 1 at the same edge.
- R5: Process 0 is granted only when cond_i[0] is high and cond_i[3:1] are all low. It increases X by 1 and leaves Y unchanged.
- R6: At most one process is applied per edge. A requesting process that loses changes neither X nor Y, so the result of any mix of requests equals the result of the winning process alone.
- R7: With cond_i all zero, X and Y keep their values.
- R8: X and Y are 16-bit two's-complement values that wrap: 0x0000 minus 1 gives 0xFFFF, and 0xFFFF plus 1 gives 0x0000.
- R9: fired_o is a registered one-hot vector in which bit p stands for process p. It is updated at the same edge as the counters, so it is visible alongside the new X and Y values, and it reads zero after an edge at which no process was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| cond_i | input | 4 | Request bit per process; bit p belongs to process p |
| x_o | output | 16 | Current value of counter X |
| y_o | output | 16 | Current value of counter Y |
| fired_o | output | 4 | One-hot flag of the process applied at the last edge |

## Verification
Any two or more processes can request in the same cycle, and all of them contend for X. The critical case is a lower-urgency process whose Y change would be harmless on its own, but which must also be held off because it lost X. The bench drives all sixteen request combinations back to back from a moving counter state. After each edge it compares X, Y and the flag vector with a model that grants by urgency and commits only the winner. Wrap checks run from zero in both directions, and an idle edge after each grant confirms that the flags clear.

// File: rtl/apu_pkg.sv
package apu_pkg;

  localparam int NPROC = 4;
  localparam int NREG  = 2;
  localparam int REG_X = 0;
  localparam int REG_Y = 1;

  // process sitting at a given urgency rank (rank 0 = most urgent)
  function automatic int proc_at_rank(input int rank);
    case (rank)
      0:       return 2;
      1:       return 3;
      2:       return 1;
      default: return 0;
    endcase
  endfunction

  // signed change a process applies to a register
  function automatic int step_of(input int p, input int r);
    int d;
    d = 0;
    case (p)
      0: d = (r == REG_X) ?  1 :  0;
      1: d = (r == REG_X) ? -1 :  1;
      2: d = (r == REG_X) ?  1 : -1;
      3: d = (r == REG_X) ?  2 : -2;
      default: d = 0;
    endcase
    return d;
  endfunction

  // registers a process writes
  function automatic logic [NREG-1:0] write_set(input int p);
    logic [NREG-1:0] m;
    for (int r = 0; r < NREG; r++) begin
      m[r] = (step_of(p, r) != 0);
    end
    return m;
  endfunction

endpackage

// File: rtl/apu_arbiter.sv
module apu_arbiter
  import apu_pkg::*;
(
  input  logic [NPROC-1:0] req,
  output logic [NPROC-1:0] grant
);

  logic [NREG-1:0] claimed;

  // walk urgency ranks; a process wins only if none of its registers is claimed
  always_comb begin
    claimed = '0;
    grant   = '0;
    for (int rank = 0; rank < NPROC; rank++) begin
      if (req[proc_at_rank(rank)] &&
          ((claimed & write_set(proc_at_rank(rank))) == '0)) begin
        grant[proc_at_rank(rank)] = 1'b1;
        claimed = claimed | write_set(proc_at_rank(rank));
      end
    end
  end

endmodule

// File: rtl/apu_regslot.sv
module apu_regslot
  import apu_pkg::*;
#(
  parameter int W       = 16,
  parameter int REG_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] grant,
  output logic [W-1:0]     q
);

  logic [W-1:0]     step_tab [NPROC];
  logic [NPROC-1:0] touch;
  logic [NPROC-1:0] writers;
  logic [W-1:0]     step_sel;
  logic [W-1:0]     q_nxt;
  logic             q_en;

  for (genvar p = 0; p < NPROC; p++) begin : g_tab
    assign step_tab[p] = W'(step_of(p, REG_IDX));
    assign touch[p]    = write_set(p)[REG_IDX];
  end

  assign writers = grant & touch;

  // AND-OR select of the single writer's step
  always_comb begin
    step_sel = '0;
    for (int p = 0; p < NPROC; p++) begin
      step_sel = step_sel | (step_tab[p] & {W{writers[p]}});
    end
  end

  assign q_en  = |writers;
  assign q_nxt = q + step_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(writers)); // R6

  AST_UNWRITTEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (writers == '0) |=> $stable(q)); // R7

endmodule

// File: rtl/atomic_pair_updater.sv
module atomic_pair_updater
  import apu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPROC-1:0] cond_i,
  output logic [W-1:0]     x_o,
  output logic [W-1:0]     y_o,
  output logic [NPROC-1:0] fired_o
);

  logic [NPROC-1:0] grant;
  logic [W-1:0]     reg_q [NREG];
  logic [NPROC-1:0] fired_nxt;
  logic             fired_en;

  apu_arbiter u_arb (
    .req   (cond_i),
    .grant (grant)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    apu_regslot #(.W(W), .REG_IDX(r)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .grant (grant),
      .q     (reg_q[r])
    );
  end

  assign x_o = reg_q[REG_X];
  assign y_o = reg_q[REG_Y];

  assign fired_nxt = grant;
  assign fired_en  = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_o <= '0;
    end else if (fired_en) begin
      fired_o <= fired_nxt;
    end
  end

  AST_TOP_ALWAYS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cond_i[2] |=> (fired_o == 4'b0100) && (x_o == $past(x_o) + W'(1))
                  && (y_o == $past(y_o) - W'(1))); // R2

  AST_P3_BELOW_P2: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i[3] && !cond_i[2]) |=> (fired_o == 4'b1000)
                  && (y_o == $past(y_o) - W'(2))); // R3

  AST_P1_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i[1] && !cond_i[2] && !cond_i[3]) |=> (x_o == $past(x_o) - W'(1))
                  && (y_o == $past(y_o) + W'(1))); // R4

  AST_LOWEST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i[0] && (cond_i[3:1] != 3'b000)) |=> !fired_o[0]); // R5

  AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fired_o)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_i == '0) |=> $stable(x_o) && $stable(y_o) && (fired_o == '0)); // R7

endmodule

// File: tb/atomic_pair_updater_bench.sv
module atomic_pair_updater_bench;

  logic        clk;
  logic        rst_n;
  logic [3:0]  cond;
  logic [15:0] x, y;
  logic [3:0]  fired;

  logic [15:0] mx, my;
  logic [3:0]  mf;
  int n_chk;
  int n_bad;
  bit done;

  atomic_pair_updater u_atomic_pair_updater (
    .clk     (clk),
    .rst_n   (rst_n),
    .cond_i  (cond),
    .x_o     (x),
    .y_o     (y),
    .fired_o (fired)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // model from the requirements: urgency 2 > 3 > 1 > 0, winner commits alone
  task automatic model_step(input logic [3:0] c);
    if (c[2]) begin
      mf = 4'b0100; mx = mx + 16'd1; my = my - 16'd1;
    end else if (c[3]) begin
      mf = 4'b1000; mx = mx + 16'd2; my = my - 16'd2;
    end else if (c[1]) begin
      mf = 4'b0010; mx = mx - 16'd1; my = my + 16'd1;
    end else if (c[0]) begin
      mf = 4'b0001; mx = mx + 16'd1;
    end else begin
      mf = 4'b0000;
    end
  endtask

  task automatic check_state(input string tag);
    n_chk++;
    if (x !== mx || y !== my || fired !== mf) begin
      n_bad++;
      $display("FAIL %s: x=%h y=%h fired=%b expected x=%h y=%h fired=%b",
               tag, x, y, fired, mx, my, mf);
    end
  endtask

  task automatic apply(input logic [3:0] c, input string tag);
    @(negedge clk);
    cond = c;
    model_step(c);
    @(posedge clk);
    #1;
    check_state(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    cond  = 4'b0000;
    rst_n = 1'b0;
    #1;
    mx = '0; my = '0; mf = '0;
    check_state("R1 reset value");
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    apply(4'b0000, "R1 after release idle");
  endtask

  task automatic t_each_alone();
    do_reset();
    apply(4'b0100, "R2 p2 alone");
    apply(4'b1000, "R3 p3 alone");
    apply(4'b0010, "R4 p1 alone");
    apply(4'b0001, "R5 p0 alone");
    apply(4'b0000, "R9 flags clear on idle");
  endtask

  task automatic t_all_combos();
    do_reset();
    apply(4'b1000, "R3 preload");
    apply(4'b1000, "R3 preload");
    for (int i = 0; i < 16; i++) begin
      apply(4'(i), "R6 combo");
    end
    for (int i = 15; i >= 0; i--) begin
      apply(4'(i), "R6 combo reverse");
    end
  endtask

  task automatic t_conflicts();
    do_reset();
    apply(4'b1100, "R2 p2 beats p3");
    apply(4'b1010, "R3 p3 beats p1");
    apply(4'b0011, "R5 p0 blocked by p1, x not touched twice");
    apply(4'b1001, "R5 p0 blocked by p3");
    apply(4'b1111, "R2 all request");
  endtask

  task automatic t_idle_hold();
    do_reset();
    apply(4'b0001, "R5 set x");
    apply(4'b0000, "R7 hold 1");
    apply(4'b0000, "R7 hold 2");
    apply(4'b0000, "R7 hold 3");
  endtask

  task automatic t_wrap();
    do_reset();
    apply(4'b0010, "R8 x underflow to FFFF");
    apply(4'b0100, "R8 x overflow to 0000");
    apply(4'b0100, "R8 y 0000 to FFFF");
    apply(4'b1000, "R8 y FFFF to FFFD");
    apply(4'b0010, "R8 y back");
  endtask

  task automatic t_midrun_reset();
    apply(4'b1000, "R3 before reset");
    do_reset();
    apply(4'b0000, "R1 idle after mid reset");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    cond = 4'b0000; rst_n = 1'b0;
    mx = '0; my = '0; mf = '0;
    repeat (2) @(posedge clk);
    t_reset();
    t_each_alone();
    t_conflicts();
    t_all_combos();
    t_idle_hold();
    t_wrap();
    t_midrun_reset();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule